// File: doc/BRIEF.md
# Multichannel DMA Register Decoder

This block is the configuration target of a DMA engine with up to eight independent channels. It takes single 32-bit register reads and writes from a host bus. It routes each one into a per-channel bank and answers each with exactly one response, which carries read data and an error flag. The data movers sit beside it. From it they receive a source address, a destination address, a byte count, an interrupt-disable flag and two one-cycle pulses: one that launches a transfer and one that cleanly resets the channel. They return a 32-bit status word per channel, and the block reads that word back through the length offset.

The block owns a 32 KB segment aligned on a 32 KB boundary. Each channel gets its own 4 KB window, so address protection can be applied per channel. Only the channel field and the five low register bits are decoded. The block flags every access that falls outside its segment, so it can also serve as the default target of an interconnect. An access to a channel that is not built, an undefined offset, or a read of the write-only reset register is refused with an error and has no effect.

Top module: `dmadec_top`

## Requirements
- R1: Every request cycle (`req_valid` high) produces exactly one response cycle (`resp_valid` high) on the following clock. No response appears in a cycle that follows a clock with no request.
- R2: A request whose address bits [31:15] differ from bits [31:15] of `SEG_BASE` gets `resp_err`=1, and it changes no register and raises no pulse.
- R3: Address bits [14:12] give the channel index. An index of `NCH` or more gets `resp_err`=1 and has no effect.
- R4: Register offset bits [4:0] = 0x00 hold the source address and 0x04 holds the destination address. Both can be read and written. Address bits [11:5] are ignored, so every alias reaches the same register.
- R5: A write to offset 0x08 stores the byte count on `ch_len`. It also raises that channel's `ch_start` bit for exactly the cycle in which its response is valid. No other channel's bit rises.
- R6: A read of offset 0x08 returns that channel's `ch_status` word unchanged.
- R7: A write of any value to offset 0x0C raises that channel's `ch_reset` bit for the response cycle only. A read of 0x0C is refused with `resp_err`=1.
- R8: Offset 0x10 is the interrupt-disable register. A nonzero write sets `ch_irq_off`, and a zero write clears it. A read returns the flag in bit 0 with zeros above it. After reset the flag is 0.
- R9: Any other offset gets `resp_err`=1. This covers 0x14 to 0x1F and every offset with bits [1:0] nonzero. An errored response carries `resp_rdata`=0.
- R10: After reset, all stored registers are 0, no pulse is raised and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response present (one cycle after request) |
| resp_rdata | output | 32 | Read data, zero on error and on writes |
| resp_err | output | 1 | Access refused |
| ch_src | output | NCH*32 | Source address per channel, channel k at bits [32k+31:32k] |
| ch_dst | output | NCH*32 | Destination address per channel |
| ch_len | output | NCH*32 | Byte count per channel |
| ch_start | output | NCH | One-cycle transfer launch per channel |
| ch_reset | output | NCH | One-cycle clean reset per channel |
| ch_irq_off | output | NCH | Interrupt disable flag per channel |
| ch_status | input | NCH*32 | Status word per channel, returned on length reads |

## Verification
The bench builds five channels so that indices 5 to 7 stay unbuilt. It sweeps every built channel and every register offset, and it changes the ignored address bits [11:5] between a write and its read-back. A decoder that used those bits, or that wrapped an out-of-range index onto a real channel, would read back the wrong word or corrupt a neighbour. The bench then compares every register against its own model. It also records the start and reset pulse vectors on each response cycle. A design that pulsed the wrong channel, pulsed on a refused access or on a status read, or let a refused write reach a bank is caught by that pulse vector or by a read-back mismatch. Out-of-segment addresses, a read of the reset offset and misaligned offsets must all return an error with zero data.

// File: rtl/dmadec_pkg.sv
package dmadec_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int SEG_LSB = 15;
  localparam int CH_LSB  = 12;
  localparam int CH_W    = 3;
  localparam int OFS_W   = 5;

  localparam logic [OFS_W-1:0] OFS_SRC = 5'h00;
  localparam logic [OFS_W-1:0] OFS_DST = 5'h04;
  localparam logic [OFS_W-1:0] OFS_LEN = 5'h08;
  localparam logic [OFS_W-1:0] OFS_RST = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_IRQ = 5'h10;

  typedef enum logic [2:0] {
    SEL_SRC, SEL_DST, SEL_LEN, SEL_RST, SEL_IRQ, SEL_NONE
  } reg_sel_e;

  function automatic logic seg_match(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
    return a[ADDR_W-1:SEG_LSB] == base[ADDR_W-1:SEG_LSB];
  endfunction

  function automatic logic [CH_W-1:0] chan_field(input logic [ADDR_W-1:0] a);
    return a[CH_LSB+CH_W-1:CH_LSB];
  endfunction

  function automatic reg_sel_e sel_of(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a[OFS_W-1:0])
      OFS_SRC: s = SEL_SRC;
      OFS_DST: s = SEL_DST;
      OFS_LEN: s = SEL_LEN;
      OFS_RST: s = SEL_RST;
      OFS_IRQ: s = SEL_IRQ;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic is_write_only(input reg_sel_e s);
    return s == SEL_RST;
  endfunction
endpackage

// File: rtl/dmadec_addr_dec.sv
module dmadec_addr_dec
  import dmadec_pkg::*;
#(
  parameter int NCH = 8,
  parameter logic [ADDR_W-1:0] SEG_BASE = 32'h0000_8000
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              seg_hit,
  output logic              acc_ok,
  output logic              acc_err,
  output reg_sel_e          sel,
  output logic [CH_W-1:0]   chan,
  output logic [NCH-1:0]    wr_en
);
  logic chan_ok;
  logic perm_ok;

  always_comb begin
    seg_hit = seg_match(req_addr, SEG_BASE);
    chan    = chan_field(req_addr);
    sel     = sel_of(req_addr);
    chan_ok = int'(chan) < NCH;
    perm_ok = (sel != SEL_NONE) && (req_write || !is_write_only(sel));
    acc_ok  = req_valid && seg_hit && chan_ok && perm_ok;
    acc_err = req_valid && !acc_ok;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_wr
    assign wr_en[k] = acc_ok && req_write && (int'(chan) == k);
  end
endmodule

// File: rtl/dmadec_chan_bank.sv
module dmadec_chan_bank
  import dmadec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] dst,
  output logic [DATA_W-1:0] len,
  output logic              irq_off,
  output logic              start,
  output logic              rst_pls,
  output logic [DATA_W-1:0] rd_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src     <= '0;
      dst     <= '0;
      len     <= '0;
      irq_off <= 1'b0;
      start   <= 1'b0;
      rst_pls <= 1'b0;
    end else begin
      start   <= wr && (sel == SEL_LEN);
      rst_pls <= wr && (sel == SEL_RST);
      if (wr) begin
        case (sel)
          SEL_SRC: src     <= wdata;
          SEL_DST: dst     <= wdata;
          SEL_LEN: len     <= wdata;
          SEL_IRQ: irq_off <= |wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_SRC: rd_word = src;
      SEL_DST: rd_word = dst;
      SEL_LEN: rd_word = status;
      SEL_IRQ: rd_word = {{(DATA_W-1){1'b0}}, irq_off};
      default: rd_word = '0;
    endcase
  end

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_IRQ) |=> $stable(irq_off));

  // R5
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_LEN) |=> $stable(len));
endmodule

// File: rtl/dmadec_resp.sv
module dmadec_resp
  import dmadec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              acc_err,
  input  logic [DATA_W-1:0] rd_word,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              resp_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      resp_err   <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= acc_err;
      resp_rdata <= (req_valid && !req_write && !acc_err) ? rd_word : '0;
    end
  end

  // R1
  one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R1
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  // R9
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_valid && resp_rdata == '0));
endmodule

// File: rtl/dmadec_top.sv
module dmadec_top
  import dmadec_pkg::*;
#(
  parameter int NCH = 8,
  parameter logic [31:0] SEG_BASE = 32'h0000_8000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [31:0]     req_addr,
  input  logic [31:0]     req_wdata,
  output logic            resp_valid,
  output logic [31:0]     resp_rdata,
  output logic            resp_err,
  output logic [NCH*32-1:0] ch_src,
  output logic [NCH*32-1:0] ch_dst,
  output logic [NCH*32-1:0] ch_len,
  output logic [NCH-1:0]  ch_start,
  output logic [NCH-1:0]  ch_reset,
  output logic [NCH-1:0]  ch_irq_off,
  input  logic [NCH*32-1:0] ch_status
);
  logic            seg_hit;
  logic            acc_ok;
  logic            acc_err;
  reg_sel_e        sel;
  logic [CH_W-1:0] chan;
  logic [NCH-1:0]  wr_en;
  logic [DATA_W-1:0] rd_vec [NCH];
  logic [DATA_W-1:0] rd_word;

  dmadec_addr_dec #(.NCH(NCH), .SEG_BASE(SEG_BASE)) dec_i (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .seg_hit   (seg_hit),
    .acc_ok    (acc_ok),
    .acc_err   (acc_err),
    .sel       (sel),
    .chan      (chan),
    .wr_en     (wr_en)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    dmadec_chan_bank bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_en[k]),
      .sel     (sel),
      .wdata   (req_wdata),
      .status  (ch_status[k*32 +: 32]),
      .src     (ch_src[k*32 +: 32]),
      .dst     (ch_dst[k*32 +: 32]),
      .len     (ch_len[k*32 +: 32]),
      .irq_off (ch_irq_off[k]),
      .start   (ch_start[k]),
      .rst_pls (ch_reset[k]),
      .rd_word (rd_vec[k])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NCH; k++) begin
      if (int'(chan) == k) rd_word = rd_vec[k];
    end
  end

  dmadec_resp resp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .acc_err    (acc_err),
    .rd_word    (rd_word),
    .resp_valid (resp_valid),
    .resp_rdata (resp_rdata),
    .resp_err   (resp_err)
  );

  // R3
  single_bank_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  // R2
  out_of_seg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !seg_hit) |=> (resp_err && ch_start == '0 && ch_reset == '0));

  // R5
  start_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start != '0) |-> ($past(acc_ok && req_write) && !resp_err && $onehot(ch_start)));

  // R7
  reset_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_reset != '0) |-> ($past(acc_ok && req_write) && !resp_err && $onehot(ch_reset)));
endmodule

// File: tb/dmadec_top_tb_top.sv
module dmadec_top_tb_top;
  localparam int NB = 5;
  localparam logic [31:0] SEG = 32'h1234_8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic [NB*32-1:0] ch_src, ch_dst, ch_len, ch_status;
  logic [NB-1:0] ch_start, ch_reset, ch_irq_off;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  logic        g_valid, g_err;
  logic [31:0] g_rdata;
  logic [NB-1:0] g_start, g_rst;
  logic        g_idle_valid;

  logic [31:0] m_src [NB];
  logic [31:0] m_dst [NB];
  logic [31:0] m_len [NB];
  logic        m_irq [NB];

  always #10 clk = ~clk;

  for (genvar k = 0; k < NB; k++) begin : g_st
    assign ch_status[k*32 +: 32] = 32'hA500_0000 + 32'(k * 17) + 32'h30;
  end

  dmadec_top #(.NCH(NB), .SEG_BASE(SEG)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
    .ch_src(ch_src), .ch_dst(ch_dst), .ch_len(ch_len),
    .ch_start(ch_start), .ch_reset(ch_reset), .ch_irq_off(ch_irq_off),
    .ch_status(ch_status)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input int ch, input int alias_v, input logic [4:0] ofs);
    return SEG | (32'(ch) << 12) | (32'(alias_v & 127) << 5) | 32'(ofs);
  endfunction

  function automatic logic [31:0] stat_of(input int ch);
    return 32'hA500_0000 + 32'(ch * 17) + 32'h30;
  endfunction

  task automatic acc(input logic wr, input logic [31:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    g_valid = resp_valid; g_err = resp_err; g_rdata = resp_rdata;
    g_start = ch_start; g_rst = ch_reset;
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
    g_idle_valid = resp_valid;
  endtask

  task automatic expect_ok_read(input string tag, input logic [31:0] a, input logic [31:0] exp);
    acc(1'b0, a, 32'h0);
    check({tag, " valid R1"}, {31'b0, g_valid}, 32'd1);
    check({tag, " err"}, {31'b0, g_err}, 32'd0);
    check({tag, " data"}, g_rdata, exp);
    check({tag, " no pulses"}, {27'b0, g_start | g_rst}, 32'd0);
  endtask

  task automatic expect_err(input string tag, input logic wr, input logic [31:0] a, input logic [31:0] d);
    acc(wr, a, d);
    check({tag, " err R9"}, {31'b0, g_err}, 32'd1);
    check({tag, " zero data R9"}, g_rdata, 32'd0);
    check({tag, " no pulses"}, {27'b0, g_start | g_rst}, 32'd0);
  endtask

  task automatic verify_all(input string tag);
    for (int k = 0; k < NB; k++) begin
      check({tag, " src port"}, ch_src[k*32 +: 32], m_src[k]);
      check({tag, " dst port"}, ch_dst[k*32 +: 32], m_dst[k]);
      check({tag, " len port"}, ch_len[k*32 +: 32], m_len[k]);
      check({tag, " irq port"}, {31'b0, ch_irq_off[k]}, {31'b0, m_irq[k]});
      expect_ok_read({tag, " src rd R4"}, mk_addr(k, k * 11 + 3, 5'h00), m_src[k]);
      expect_ok_read({tag, " dst rd R4"}, mk_addr(k, k * 7 + 90, 5'h04), m_dst[k]);
      expect_ok_read({tag, " irq rd R8"}, mk_addr(k, 127, 5'h10), {31'b0, m_irq[k]});
    end
  endtask

  initial begin
    for (int k = 0; k < NB; k++) begin
      m_src[k] = '0; m_dst[k] = '0; m_len[k] = '0; m_irq[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 resp_valid", {31'b0, resp_valid}, 32'd0);
    check("R10 pulses", {27'b0, ch_start | ch_reset}, 32'd0);
    check("R10 irq", {27'b0, ch_irq_off}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 src after reset", ch_src[31:0], 32'd0);
    verify_all("R10 R8 reset");

    // R4 write src/dst through aliases, R8 irq flag
    for (int k = 0; k < NB; k++) begin
      m_src[k] = 32'h1000_0000 * 32'(k + 1) ^ 32'h0000_0F04 * 32'(k + 3);
      m_dst[k] = ~m_src[k] + 32'(k * 4);
      acc(1'b1, mk_addr(k, k * 29 + 5, 5'h00), m_src[k]);
      check("R4 wr ok", {31'b0, g_err}, 32'd0);
      check("R1 idle after resp", {31'b0, g_idle_valid}, 32'd0);
      acc(1'b1, mk_addr(k, 64 + k, 5'h04), m_dst[k]);
      m_irq[k] = (k % 2) == 1;
      acc(1'b1, mk_addr(k, 0, 5'h10), m_irq[k] ? 32'h8000_0000 : 32'h0);
    end
    verify_all("R4 R8 sweep");

    // R8 clear with zero after setting
    acc(1'b1, mk_addr(3, 0, 5'h10), 32'h0);
    m_irq[3] = 1'b0;
    acc(1'b1, mk_addr(0, 5, 5'h10), 32'h0000_0002);
    m_irq[0] = 1'b1;

    // R5 length write starts only its channel; R6 status read
    for (int k = 0; k < NB; k++) begin
      m_len[k] = 32'd64 * 32'(k + 1) + 32'd12;
      acc(1'b1, mk_addr(k, k * 3, 5'h08), m_len[k]);
      check("R5 start onehot", {27'b0, g_start}, 32'(1 << k));
      check("R5 no reset", {27'b0, g_rst}, 32'd0);
      check("R5 start one cycle", {27'b0, ch_start}, 32'd0);
      check("R5 len port", ch_len[k*32 +: 32], m_len[k]);
      expect_ok_read("R6 status", mk_addr(k, 100 - k, 5'h08), stat_of(k));
    end

    // R7 reset register pulses, any value
    for (int k = 0; k < NB; k++) begin
      acc(1'b1, mk_addr(k, 9, 5'h0C), (k == 2) ? 32'h0 : 32'hDEAD_0000 + 32'(k));
      check("R7 reset onehot", {27'b0, g_rst}, 32'(1 << k));
      check("R7 no start", {27'b0, g_start}, 32'd0);
      check("R7 wr ok", {31'b0, g_err}, 32'd0);
      check("R7 pulse one cycle", {27'b0, ch_reset}, 32'd0);
      expect_err("R7 read wo", 1'b0, mk_addr(k, 1, 5'h0C), 32'h0);
    end

    // R3 unbuilt channels; R9 undefined and misaligned offsets
    for (int c = NB; c < 8; c++) begin
      for (int o = 0; o < 32; o++) begin
        expect_err("R3 chan range", 1'b1, mk_addr(c, o, 5'(o)), 32'hFFFF_FFFF);
        expect_err("R3 chan range rd", 1'b0, mk_addr(c, o, 5'(o)), 32'h0);
      end
    end
    for (int k = 0; k < NB; k++) begin
      for (int o = 0; o < 32; o++) begin
        if (o != 0 && o != 4 && o != 8 && o != 12 && o != 16) begin
          expect_err("R9 bad offset", 1'b1, mk_addr(k, o * 3, 5'(o)), 32'h5555_AAAA);
          expect_err("R9 bad offset rd", 1'b0, mk_addr(k, o, 5'(o)), 32'h0);
        end
      end
    end

    // R2 outside the segment, including the adjacent segment and low memory
    for (int k = 0; k < 8; k++) begin
      expect_err("R2 next seg", 1'b1, mk_addr(k, 0, 5'h08) ^ 32'h0000_8000, 32'h1);
      expect_err("R2 low mem", 1'b1, 32'(k) << 12 | 32'h0C, 32'h1);
      expect_err("R2 high bit", 1'b0, mk_addr(k, 0, 5'h00) ^ 32'h8000_0000, 32'h0);
    end

    verify_all("R2 R3 R9 no effect");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule